// File: doc/BRIEF.md
# Serial Flash Continuous Read Engine

This block is the slave side of a serial-flash read path. A host selects it by pulling `sel_n` low, clocks in an 8-bit command and a 24-bit start address on `mosi`, then clocks a fixed number of dummy bytes. After that, every further serial clock shifts one bit of array data out on `miso`. An internal page/offset counter moves on by one byte after each byte that is sent, so a single command can stream the whole array. When the stream reaches the end of a page it goes on into the next page, and after the last page it returns to page 0, with no idle clocks in either case.

Two read commands are recognised. They differ only in how many dummy bytes come before the data. A static mode input selects pages of 264 bytes or pages of 256 bytes, and this choice changes how the address is split and where the offset counter wraps. The serial pins are oversampled in the system clock domain, so the serial clock must be several times slower than `clk`. The main array is a read-only register array that is filled with a computed pattern when it is initialised.

Top module: `sfr_read_engine`

## Requirements
- R1: Synchronous reset (active high) drives `miso_en` and `miso` low.
- R2: A transaction begins only when `sel_n` falls. Whenever `sel_n` rises, the transaction ends and `miso_en` is low within 4 `clk` cycles.
- R3: `mosi` is sampled on rising serial-clock edges, and `miso` changes only after falling edges. Every field is sent most significant bit first. Both clock idle levels (low and high) work.
- R4: Command 8'hE8 is followed by 3 address bytes and then 4 dummy bytes. The most significant bit of the first data byte appears after the first falling edge that follows the last dummy bit.
- R5: Command 8'h0B is followed by 3 address bytes and then exactly 1 dummy byte, after which data appears in the same way as in R4.
- R6: With `pg264_mode`=1, address bits [19:9] give the page and bits [8:0] give the byte offset. Only the low log2(PAGES) page bits are used.
- R7: With `pg264_mode`=0, address bits [18:8] give the page and bits [7:0] give the byte offset. Only the low log2(PAGES) page bits are used.
- R8: In 264-byte mode, the byte after offset 263 is offset 0 of the next page, with no gap.
- R9: In 256-byte mode, the byte after offset 255 is offset 0 of the next page, with no gap.
- R10: After the last byte of page PAGES-1 comes byte 0 of page 0, with no gap.
- R11: Any other command value keeps `miso_en` low until `sel_n` rises, and it does not affect the next transaction.
- R12: Raising `sel_n` in the middle of a data byte stops the stream. The next command starts again from its own address.
- R13: The byte at linear location L (page*264+offset or page*256+offset) is (5*L + floor(L/256)) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial command/address input |
| pg264_mode | input | 1 | 1 selects 264-byte pages, 0 selects 256-byte pages |
| miso | output | 1 | Serial data output |
| miso_en | output | 1 | Output enable for `miso` (low means high impedance) |

## Verification
If the bit counter, the dummy length or the page/offset counter holds a wrong value, the streamed bytes come out of order, and the first byte received already shows the fault. The one exception is a wrap fault, which appears at the first page crossing. For that reason the streams start a few bytes before offset 263 or 255, and before the last page, so that a crossing happens within the first handful of bytes. A wrong dummy count moves the data by whole bytes, which the expected-byte queue detects at once. A stuck enable appears as an unexpected byte after an unknown command, or as `miso_en` still high a few cycles after select is released.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } sfr_state_e;

  localparam logic [7:0] OP_LEGACY    = 8'hE8;
  localparam logic [7:0] OP_FAST      = 8'h0B;
  localparam int         DUMMY_LEGACY = 4;
  localparam int         DUMMY_FAST   = 1;
  localparam int         ADDR_BITS    = 24;
  localparam int         OFS_W        = 9;

  // initial array contents: byte at linear location lin
  function automatic logic [7:0] sfr_fill(input int unsigned lin);
    return 8'((lin * 5) + (lin >> 8));
  endfunction

endpackage

// File: rtl/sfr_sync_edge.sv
module sfr_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {(STAGES + 1){RST_VAL}};
    else     chain <= {chain[STAGES-1:0], d};
  end

  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/sfr_addr_ctr.sv
module sfr_addr_ctr import sfr_pkg::*; #(
  parameter int PAGES = 8,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int DEPTH  = PAGES * 264,
  localparam int LIN_W  = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 adv,
  input  logic                 pg264,
  input  logic [ADDR_BITS-1:0] addr,
  output logic [LIN_W-1:0]     lin
);

  logic [PAGE_W-1:0]    pg_q;
  logic [OFS_W-1:0]     ofs_q;
  logic [OFS_W-1:0]     last_ofs;
  logic [ADDR_BITS-1:0] addr_unused_copy;

  assign addr_unused_copy = addr;
  assign last_ofs = pg264 ? OFS_W'(263) : OFS_W'(255);

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q  <= '0;
      ofs_q <= '0;
    end else if (load) begin
      if (pg264) begin
        pg_q  <= addr[9 +: PAGE_W];
        ofs_q <= addr[8:0];
      end else begin
        pg_q  <= addr[8 +: PAGE_W];
        ofs_q <= {1'b0, addr[7:0]};
      end
    end else if (adv) begin
      if (ofs_q == last_ofs) begin
        ofs_q <= '0;
        pg_q  <= pg_q + 1'b1;
      end else begin
        ofs_q <= ofs_q + 1'b1;
      end
    end
  end

  assign lin = LIN_W'(32'(pg_q) * (pg264 ? 32'd264 : 32'd256) + 32'(ofs_q));

  // R8 / R9: offset steps by one inside a page
  a_r8_ofs_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && ofs_q != last_ofs) |=> (ofs_q == $past(ofs_q) + 1'b1 && pg_q == $past(pg_q)));

  // R8 / R9 / R10: page crossing returns offset to 0 and bumps the page modulo PAGES
  a_r10_page_cross: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && ofs_q == last_ofs) |=> (ofs_q == '0 && pg_q == PAGE_W'($past(pg_q) + 1'b1)));

  a_r6_no_load_adv: assert property (@(posedge clk) disable iff (rst) !(load && adv));

endmodule

// File: rtl/sfr_array.sv
module sfr_array import sfr_pkg::*; #(
  parameter int DEPTH = 2112,
  localparam int LIN_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [LIN_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = sfr_fill(i);
  end

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

endmodule

// File: rtl/sfr_read_engine.sv
module sfr_read_engine import sfr_pkg::*; #(
  parameter int PAGES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic sclk,
  input  logic mosi,
  input  logic pg264_mode,
  output logic miso,
  output logic miso_en
);

  localparam int DEPTH = PAGES * 264;
  localparam int LIN_W = $clog2(DEPTH);
  localparam int SH_W  = ADDR_BITS - 1;

  logic sel_q, sel_rise, sel_fall;
  logic sclk_q_unused, sclk_rise, sclk_fall;
  logic mosi_q, mosi_rise_unused, mosi_fall_unused;

  sfr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel (
    .clk(clk), .rst(rst), .d(sel_n), .q(sel_q), .rise(sel_rise), .fall(sel_fall));
  sfr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst(rst), .d(sclk), .q(sclk_q_unused), .rise(sclk_rise), .fall(sclk_fall));
  sfr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi (
    .clk(clk), .rst(rst), .d(mosi), .q(mosi_q), .rise(mosi_rise_unused), .fall(mosi_fall_unused));

  sfr_state_e      state;
  logic [5:0]      cnt, dummy_bits;
  logic [SH_W-1:0] sh_q;
  logic [2:0]      dbit;
  logic            so_q, oe_q;
  logic [7:0]      op_now;
  logic [ADDR_BITS-1:0] addr_now;
  logic            go, load, adv;
  logic [LIN_W-1:0] lin;
  logic [7:0]      rd_data;

  assign op_now   = {sh_q[6:0], mosi_q};
  assign addr_now = {sh_q, mosi_q};
  assign go       = !sel_q && !sel_fall;
  assign load     = go && state == ST_ADDR && sclk_rise && cnt == 6'd23;
  assign adv      = go && state == ST_DATA && sclk_fall && dbit == 3'd7;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      dummy_bits <= '0;
      sh_q       <= '0;
      dbit       <= '0;
      so_q       <= 1'b0;
      oe_q       <= 1'b0;
    end else if (sel_q) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (sel_fall) begin
      state <= ST_CMD;
      cnt   <= '0;
    end else begin
      case (state)
        ST_CMD: if (sclk_rise) begin
          sh_q <= {sh_q[SH_W-2:0], mosi_q};
          if (cnt == 6'd7) begin
            cnt <= '0;
            if (op_now == OP_LEGACY) begin
              state      <= ST_ADDR;
              dummy_bits <= 6'(8 * DUMMY_LEGACY);
            end else if (op_now == OP_FAST) begin
              state      <= ST_ADDR;
              dummy_bits <= 6'(8 * DUMMY_FAST);
            end else begin
              state <= ST_SKIP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ADDR: if (sclk_rise) begin
          sh_q <= {sh_q[SH_W-2:0], mosi_q};
          if (cnt == 6'd23) begin
            cnt   <= '0;
            state <= ST_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DUMMY: if (sclk_rise) begin
          if (cnt == dummy_bits - 6'd1) begin
            cnt   <= '0;
            state <= ST_DATA;
            oe_q  <= 1'b1;
            dbit  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: if (sclk_fall) begin
          so_q <= rd_data[3'd7 - dbit];
          dbit <= dbit + 1'b1;
        end
        default: ;
      endcase
    end
  end

  sfr_addr_ctr #(.PAGES(PAGES)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .pg264(pg264_mode),
    .addr(addr_now), .lin(lin));

  sfr_array #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rd_addr(lin), .rd_data(rd_data));

  assign miso    = so_q;
  assign miso_en = oe_q;

  a_r2_sel_release_quiet: assert property (@(posedge clk) disable iff (rst)
    sel_rise |=> !oe_q);

  a_r3_out_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(so_q));

  a_r4_enable_after_dummy: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(state) == ST_DUMMY);

  a_r11_skip_silent: assert property (@(posedge clk) disable iff (rst)
    state == ST_SKIP |-> !oe_q);

endmodule

// File: tb/sim_sfr_read_engine.sv
module sim_sfr_read_engine;
  localparam int PAGES = 8;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b1, sclk = 1'b0, mosi = 1'b0, pg264_mode = 1'b1;
  logic miso, miso_en;
  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string cur_req = "R4";

  always #2 clk = ~clk;

  sfr_read_engine #(.PAGES(PAGES)) u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .mosi(mosi),
    .pg264_mode(pg264_mode), .miso(miso), .miso_en(miso_en));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] model_byte(input bit m264, input int pg, input int ofs);
    int l;
    l = m264 ? pg * 264 + ofs : pg * 256 + ofs;
    return 8'((5 * l + l / 256) % 256);
  endfunction

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0;
    mosi = b;
    wait_half();
    sclk = 1'b1;
    wait_half();
  endtask

  // driver: pushes expected bytes, then clocks the transaction
  task automatic run_read(input logic [7:0] op, input logic [23:0] addr, input int dummies,
                          input int nbytes, input int extra_bits, input bit mode3,
                          input bit expect_data);
    int pg, ofs, sz;
    sz  = pg264_mode ? 264 : 256;
    pg  = pg264_mode ? (addr >> 9) % PAGES : (addr >> 8) % PAGES;
    ofs = pg264_mode ? addr & 24'h1FF : addr & 24'hFF;
    if (expect_data) begin
      for (int k = 0; k < nbytes; k++) begin
        exp_q.push_back(model_byte(pg264_mode, pg, ofs));
        ofs++;
        if (ofs == sz) begin
          ofs = 0;
          pg = (pg + 1) % PAGES;
        end
      end
    end
    @(negedge clk);
    sclk = mode3;
    wait_half();
    sel_n = 1'b0;
    wait_half();
    for (int b = 7; b >= 0; b--) send_bit(op[b]);
    for (int b = 23; b >= 0; b--) send_bit(addr[b]);
    for (int b = 0; b < dummies * 8; b++) send_bit(1'b0);
    for (int b = 0; b < nbytes * 8 + extra_bits; b++) send_bit(1'b0);
    if (!expect_data) check(miso_en == 1'b0, "R11", "enable after unknown command", miso_en, 0);
    else check(miso_en == 1'b1, cur_req, "enable during stream", miso_en, 1);
    sclk = mode3;
    wait_half();
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
    check(miso_en == 1'b0, "R2", "enable after select release", miso_en, 0);
    wait_half();
  endtask

  // monitor: assembles bytes on rising serial clock and pops the scoreboard
  initial begin
    logic [7:0] acc;
    int nb;
    acc = '0;
    nb = 0;
    forever begin
      @(posedge sclk or posedge sel_n);
      if (sel_n) nb = 0;
      else if (miso_en) begin
        acc = {acc[6:0], miso};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) check(1'b0, "R11", "unexpected byte", acc, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(acc == e, cur_req, "stream byte", acc, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(miso_en == 1'b0, "R1", "enable after reset", miso_en, 0);
    check(miso == 1'b0, "R1", "output after reset", miso, 0);

    // R4 R6 R13: legacy command, 264-byte pages
    pg264_mode = 1'b1; cur_req = "R4_R6_R13";
    run_read(8'hE8, (24'd2 << 9) | 24'd5, 4, 6, 0, 1'b0, 1'b1);

    // R5 R8: fast command crossing a 264-byte page end
    cur_req = "R5_R8";
    run_read(8'h0B, (24'd3 << 9) | 24'd260, 1, 8, 0, 1'b0, 1'b1);

    // R7 R9 R3: 256-byte pages, clock idle high
    pg264_mode = 1'b0; cur_req = "R7_R9_R3";
    run_read(8'h0B, (24'd1 << 8) | 24'd250, 1, 10, 0, 1'b1, 1'b1);

    // R10: last page wrap, 264-byte mode, high page and top bits ignored
    pg264_mode = 1'b1; cur_req = "R10_R6";
    run_read(8'hE8, 24'hA00000 | (24'h7FF << 9) | 24'd262, 4, 4, 0, 1'b0, 1'b1);

    // R10: last page wrap, 256-byte mode
    pg264_mode = 1'b0; cur_req = "R10_R7";
    run_read(8'h0B, (24'h7FF << 8) | 24'd254, 1, 4, 0, 1'b0, 1'b1);

    // R11: unknown command produces nothing
    cur_req = "R11";
    run_read(8'h9F, 24'h000000, 0, 3, 0, 1'b0, 1'b0);
    check(exp_q.size() == 0, "R11", "scoreboard after unknown command", exp_q.size(), 0);

    // R12: abort mid byte, then a fresh read from a new address
    pg264_mode = 1'b1; cur_req = "R12";
    run_read(8'h0B, (24'd1 << 9), 1, 2, 3, 1'b0, 1'b1);
    pg264_mode = 1'b0; cur_req = "R12_R3";
    run_read(8'hE8, (24'd5 << 8) | 24'd17, 4, 3, 0, 1'b1, 1'b1);

    check(exp_q.size() == 0, "R13", "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule